// File: doc/BRIEF.md
# OFDM Training Preamble Sample Generator

This block produces the time-domain training preamble that opens every transmitted OFDM frame. After a start pulse it streams complex baseband samples, one per sample-enable beat of the 20 Msample/s sample clock, over a valid/ready interface. First comes the short training part: a 16-sample symbol played ten times, 160 samples. Then comes the long training part, which is two and a half copies of a 64-sample symbol. That part opens with a 32-sample guard taken from the back half of the long symbol, followed by two whole copies, another 160 samples.

The frame therefore lasts 320 samples (16 µs). The generator holds the two training symbols in small internal ROMs, so it does not loop whole symbols: the guard begins in the middle of the long ROM. When the last sample has been taken, a one-cycle done pulse tells the SIGNAL-symbol path that it may take over the stream. Back-pressure from the consumer freezes both the presented sample and the sequencing state.

Top module: `preamble_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `out_valid`, `busy` and `done` are all 0 after that edge.
- R2: A `start` pulse seen while idle raises `busy` from the next cycle. `busy` stays high until the cycle in which `done` is high, and in that cycle it is low.
- R3: A new sample appears on the output only in the cycle after `smp_en` was high, and at most one new sample is presented per beat.
- R4: Samples 0 to 159 of a frame are short-ROM entry (n mod 16).
- R5: Samples 160 to 191 are long-ROM entries 32 to 63 (the guard).
- R6: Samples 192 to 319 are long-ROM entries 0 to 63, played twice.
- R7: With the default contents, short entry k carries re = 0x1000+k and im = 0x2000+k, and long entry k carries re = 0x3000+k and im = −4096+k, all as signed 16-bit values.
- R8: While `out_valid` is high and `out_ready` is low, the sample stays valid and unchanged. No sample is skipped or repeated.
- R9: Exactly 320 samples are accepted per frame. `done` is high for one cycle, in the cycle after the 320th acceptance.
- R10: A `start` seen while `busy` is high is ignored, including one that coincides with the final acceptance. A `start` in the `done` cycle begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_en | input | 1 | Sample-rate enable beat |
| start | input | 1 | Begin a preamble (ignored while busy) |
| out_ready | input | 1 | Consumer accepts the presented sample |
| out_valid | output | 1 | A sample is presented |
| out_re | output | 16 | In-phase part, signed |
| out_im | output | 16 | Quadrature part, signed |
| busy | output | 1 | Preamble in progress |
| done | output | 1 | One-cycle pulse after the last sample is taken |

## Verification
Two events can meet in one cycle: the acceptance of the 320th sample and a new `start` request. The bench raises `start` exactly in the cycle of that final acceptance and expects it to be dropped, so no second frame follows. It then raises `start` in the very cycle `done` is high and expects a full second frame, checked sample by sample. Both runs use an enable beat on every cycle, so the final acceptance and the restart land back to back.

// File: rtl/preamble_gen_pkg.sv
// Package: shared sample type, sequencing phases and the ROM fill rule.
// Assumes: samples are signed two's complement of SMP_W bits per component.
package preamble_gen_pkg;

    localparam int SMP_W = 16;

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } cplx_t;

    typedef enum logic [1:0] {
        PH_SHORT = 2'd0,
        PH_GUARD = 2'd1,
        PH_LONG  = 2'd2,
        PH_TAIL  = 2'd3
    } phase_e;

    // Compute one ROM word from the per-ROM bases and the entry index.
    function automatic cplx_t fill_word(input int re_base, input int im_base, input int k);
        cplx_t w;
        w.re = SMP_W'(re_base + k);
        w.im = SMP_W'(im_base + k);
        return w;
    endfunction

endpackage

// File: rtl/preamble_rom.sv
// Module: asynchronous-read training-symbol ROM.
// Does: holds DEPTH complex words filled at elaboration from two bases.
// Assumes: DEPTH is a power of two so that every address is in range.
module preamble_rom
    import preamble_gen_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int RE_BASE = 0,
    parameter int IM_BASE = 0,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output cplx_t         word
);

    cplx_t table_q [DEPTH];

    // Fill each entry from the package rule.
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign table_q[g] = fill_word(RE_BASE, IM_BASE, g);
    end

    // Look up the addressed entry.
    assign word = table_q[addr];

endmodule

// File: rtl/preamble_seq.sv
// Module: preamble sequencer.
// Does: walks the short part (SHORT_REPS whole symbols), then the guard
//       (tail of the long symbol), then LONG_REPS whole long symbols, and
//       raises done once the final sample has been taken.
// Assumes: SHORT_LEN <= LONG_LEN, GUARD_LEN <= LONG_LEN, and the output stage
//          reports slot_free and last_take for its single holding register.
module preamble_seq
    import preamble_gen_pkg::*;
#(
    parameter int SHORT_LEN  = 16,
    parameter int SHORT_REPS = 10,
    parameter int LONG_LEN   = 64,
    parameter int GUARD_LEN  = 32,
    parameter int LONG_REPS  = 2,
    localparam int IW        = $clog2(LONG_LEN),
    localparam int MAX_REPS  = (SHORT_REPS > LONG_REPS) ? SHORT_REPS : LONG_REPS,
    localparam int RW        = $clog2(MAX_REPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          smp_en,
    input  logic          slot_free,
    input  logic          last_take,
    output logic          load,
    output logic          rd_long,
    output logic [IW-1:0] rd_addr,
    output logic          busy,
    output logic          done
);

    localparam logic [IW-1:0] SHORT_LAST  = IW'(SHORT_LEN - 1);
    localparam logic [IW-1:0] LONG_LAST   = IW'(LONG_LEN - 1);
    localparam logic [IW-1:0] GUARD_FIRST = IW'(LONG_LEN - GUARD_LEN);
    localparam logic [RW-1:0] SREP_LAST   = RW'(SHORT_REPS - 1);
    localparam logic [RW-1:0] LREP_LAST   = RW'(LONG_REPS - 1);

    phase_e        phase_q;
    logic [IW-1:0] idx_q;
    logic [RW-1:0] rep_q;

    // Fetch one sample when running, a beat arrives and the slot is free.
    assign load    = busy && (phase_q != PH_TAIL) && smp_en && slot_free;
    assign rd_long = (phase_q != PH_SHORT);
    assign rd_addr = idx_q;

    // Advance phase, index and repeat count; track busy and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            phase_q <= PH_SHORT;
            idx_q   <= '0;
            rep_q   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    phase_q <= PH_SHORT;
                    idx_q   <= '0;
                    rep_q   <= '0;
                end
            end else if (phase_q == PH_TAIL) begin
                if (last_take) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (load) begin
                case (phase_q)
                    PH_SHORT: begin
                        if (idx_q == SHORT_LAST) begin
                            idx_q <= '0;
                            if (rep_q == SREP_LAST) begin
                                rep_q   <= '0;
                                phase_q <= (GUARD_LEN > 0) ? PH_GUARD : PH_LONG;
                                idx_q   <= (GUARD_LEN > 0) ? GUARD_FIRST : '0;
                            end else begin
                                rep_q <= rep_q + 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    PH_GUARD: begin
                        if (idx_q == LONG_LAST) begin
                            idx_q   <= '0;
                            phase_q <= PH_LONG;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    PH_LONG: begin
                        if (idx_q == LONG_LAST) begin
                            idx_q <= '0;
                            if (rep_q == LREP_LAST) begin
                                rep_q   <= '0;
                                phase_q <= PH_TAIL;
                            end else begin
                                rep_q <= rep_q + 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    default: phase_q <= PH_TAIL;
                endcase
            end
        end
    end

    // R9: done lasts exactly one cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: busy only falls together with the done pulse.
    a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5: the guard never reads the front half of the long symbol.
    a_r5_guard_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase_q == PH_GUARD) |-> (idx_q >= GUARD_FIRST));

    // R10: a start while busy leaves the position untouched unless a sample moved.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !load && phase_q != PH_TAIL) |=> ($stable(idx_q) && $stable(rep_q) && busy));

endmodule

// File: rtl/preamble_out.sv
// Module: output holding register for the sample stream.
// Does: captures a fetched sample and presents it until the consumer takes it.
// Assumes: the sequencer only fetches when slot_free is high.
module preamble_out
    import preamble_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  cplx_t din,
    input  logic  ready,
    output logic  valid,
    output cplx_t dout,
    output logic  slot_free,
    output logic  take
);

    // The slot can take a new sample when empty or being emptied this cycle.
    assign slot_free = !valid || ready;
    assign take      = valid && ready;

    // Hold or replace the presented sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R8: a stalled sample stays valid and unchanged.
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(dout)));

endmodule

// File: rtl/preamble_gen.sv
// Module: OFDM training preamble generator (top).
// Does: on start, streams the short then the long training samples on a
//       valid/ready interface, one per smp_en beat, and pulses done at the end.
// Assumes: smp_en marks the sample rate; start may be a level or a pulse.
module preamble_gen
    import preamble_gen_pkg::*;
#(
    parameter int SHORT_LEN     = 16,
    parameter int SHORT_REPS    = 10,
    parameter int LONG_LEN      = 64,
    parameter int GUARD_LEN     = 32,
    parameter int LONG_REPS     = 2,
    parameter int SHORT_RE_BASE = 32'h1000,
    parameter int SHORT_IM_BASE = 32'h2000,
    parameter int LONG_RE_BASE  = 32'h3000,
    parameter int LONG_IM_BASE  = -4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic                    start,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_re,
    output logic signed [SMP_W-1:0] out_im,
    output logic                    busy,
    output logic                    done
);

    localparam int IW  = $clog2(LONG_LEN);
    localparam int SAW = $clog2(SHORT_LEN);

    logic          load;
    logic          rd_long;
    logic [IW-1:0] rd_addr;
    logic          slot_free;
    logic          take;
    cplx_t         short_word;
    cplx_t         long_word;
    cplx_t         fetch_word;
    cplx_t         held_word;

    preamble_seq #(
        .SHORT_LEN (SHORT_LEN),
        .SHORT_REPS(SHORT_REPS),
        .LONG_LEN  (LONG_LEN),
        .GUARD_LEN (GUARD_LEN),
        .LONG_REPS (LONG_REPS)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .smp_en   (smp_en),
        .slot_free(slot_free),
        .last_take(take),
        .load     (load),
        .rd_long  (rd_long),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .done     (done)
    );

    preamble_rom #(
        .DEPTH  (SHORT_LEN),
        .RE_BASE(SHORT_RE_BASE),
        .IM_BASE(SHORT_IM_BASE)
    ) short_rom_i (
        .addr(rd_addr[SAW-1:0]),
        .word(short_word)
    );

    preamble_rom #(
        .DEPTH  (LONG_LEN),
        .RE_BASE(LONG_RE_BASE),
        .IM_BASE(LONG_IM_BASE)
    ) long_rom_i (
        .addr(rd_addr),
        .word(long_word)
    );

    // Pick the ROM that serves the current phase.
    assign fetch_word = rd_long ? long_word : short_word;

    preamble_out out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .din      (fetch_word),
        .ready    (out_ready),
        .valid    (out_valid),
        .dout     (held_word),
        .slot_free(slot_free),
        .take     (take)
    );

    assign out_re = held_word.re;
    assign out_im = held_word.im;

    // R3: a freshly presented sample follows an enable beat.
    a_r3_new_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> $past(smp_en));

    // R9: done follows an acceptance in the previous cycle.
    a_r9_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready) && !busy));

    // R1: an idle block presents nothing.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

endmodule

// File: tb/preamble_gen_tb_top.sv
// Scoreboard bench: frames are pushed as expected samples, a monitor pops and
// compares each accepted sample. Inputs change 2 ns after a rising edge and
// the monitor samples on the falling edge.
module preamble_gen_tb_top;

    localparam int TOTAL = 320;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic start = 1'b0;
    logic out_ready = 1'b0;
    logic out_valid;
    logic signed [15:0] out_re;
    logic signed [15:0] out_im;
    logic busy;
    logic done;

    preamble_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_en   (smp_en),
        .start    (start),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_re   (out_re),
        .out_im   (out_im),
        .busy     (busy),
        .done     (done)
    );

    typedef struct {
        logic [15:0] re;
        logic [15:0] im;
        int          n;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int mode = 0;
    int en_div = 1;
    int acc_cnt = 0;
    bit kick = 0;
    bit auto_last = 0;
    bit auto_done = 0;
    bit exp_done = 0;
    bit p_valid = 0, p_ready = 0, p_en = 0;
    logic [31:0] p_data = '0;

    // Expected re/im of sample n of a frame, from R4 to R7.
    function automatic logic [15:0] ref_re(int n);
        if (n < 160) return 16'(32'h1000 + n % 16);
        return 16'(32'h3000 + n % 64);
    endfunction

    function automatic logic [15:0] ref_im(int n);
        if (n < 160) return 16'(32'h2000 + n % 16);
        return 16'(-4096 + n % 64);
    endfunction

    task automatic push_frame();
        for (int n = 0; n < TOTAL; n++) begin
            exp_t e;
            e.re = ref_re(n);
            e.im = ref_im(n);
            e.n  = n;
            q.push_back(e);
        end
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: enable beats, ready pattern and start requests.
    always @(posedge clk) begin
        #2;
        cyc++;
        smp_en = (cyc % en_div) == 0;
        out_ready = (mode == 1) ? !((cyc % 5) == 2 || (cyc % 7) == 0) : 1'b1;
        start = 1'b0;
        if (kick) begin
            start = 1'b1;
            kick = 0;
        end
        if (auto_last && out_valid && out_ready && acc_cnt == TOTAL - 1) begin
            start = 1'b1;
            auto_last = 0;
        end
        if (auto_done && done) begin
            start = 1'b1;
            auto_done = 0;
            push_frame();
        end
    end

    // Monitor: scoreboard compare, hold, beat and done timing.
    always @(negedge clk) begin
        if (!rst_n) begin
            p_valid = 0;
            p_ready = 0;
            p_en = 0;
            exp_done = 0;
        end else begin
            if (done || exp_done)
                check(done == exp_done, "R9", "done pulse", 32'(done), 32'(exp_done));
            if (done)
                check(!busy, "R2", "busy low with done", 32'(busy), 32'd0);
            if (p_valid && !p_ready)
                check(out_valid && {out_re, out_im} == p_data, "R8", "stalled sample held",
                      {out_re, out_im}, p_data);
            if (out_valid && (!p_valid || p_ready))
                check(p_en, "R3", "new sample after beat", 32'(p_en), 32'd1);
            exp_done = 0;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    check(0, "R9", "unexpected extra sample", {out_re, out_im}, 32'd0);
                end else begin
                    exp_t e;
                    string tag;
                    e = q.pop_front();
                    tag = (e.n < 160) ? "R4 R7" : (e.n < 192) ? "R5 R7" : "R6 R7";
                    check({out_re, out_im} == {e.re, e.im}, tag, $sformatf("sample %0d", e.n),
                          {out_re, out_im}, {e.re, e.im});
                end
                acc_cnt++;
                if (acc_cnt == TOTAL) begin
                    exp_done = 1;
                    acc_cnt = 0;
                end
            end
            p_valid = out_valid;
            p_ready = out_ready;
            p_en = smp_en;
            p_data = {out_re, out_im};
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (q.size() != 0 || busy || out_valid || done);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=0", q.size());
        finish_run();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !busy && !done, "R1", "idle after reset",
              {29'd0, out_valid, busy, done}, 32'd0);

        // Frame 1: beat every cycle, ready always high.
        mode = 0; en_div = 1;
        push_frame();
        kick = 1;
        repeat (3) @(negedge clk);
        check(busy, "R2", "busy after start", 32'(busy), 32'd1);
        wait_idle();

        // Frame 2: sparse beats, ready stalls, and a start mid-frame (R10).
        mode = 1; en_div = 3;
        push_frame();
        kick = 1;
        repeat (200) @(negedge clk);
        kick = 1;
        wait_idle();
        repeat (20) @(negedge clk);
        check(!busy && !out_valid, "R10", "mid-frame start left no extra frame",
              {30'd0, busy, out_valid}, 32'd0);

        // Frame 3: start lands in the cycle of the final acceptance (R10).
        mode = 0; en_div = 1;
        push_frame();
        auto_last = 1;
        kick = 1;
        wait_idle();
        repeat (20) @(negedge clk);
        check(!busy && !out_valid, "R10", "start at last take ignored",
              {30'd0, busy, out_valid}, 32'd0);
        check(!auto_last, "R10", "last-take start was issued", 32'(auto_last), 32'd0);

        // Frames 4 and 5: start in the done cycle begins a new frame (R10).
        push_frame();
        auto_done = 1;
        kick = 1;
        wait_idle();
        check(!auto_done, "R10", "restart on done issued", 32'(auto_done), 32'd0);

        // Mid-frame reset returns to idle (R1).
        push_frame();
        kick = 1;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        q.delete();
        acc_cnt = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !busy && !done, "R1", "idle after mid-frame reset",
              {29'd0, out_valid, busy, done}, 32'd0);

        // One more full frame after the reset.
        push_frame();
        kick = 1;
        wait_idle();
        check(q.size() == 0, "R9", "scoreboard drained", q.size(), 32'd0);
        finish_run();
    end

endmodule